// File: doc/BRIEF.md
# Block-Based Memory Protection Controller

This controller guards a contiguous memory window by splitting it into equal blocks whose byte size is a power of two. Each block has one security bit, stored in a lookup table. Software reads and writes that table one 32-bit word at a time through a pointer register and a data window. The pointer can step forward on its own after each window access, so a whole table can be loaded or dumped with a run of accesses to one address.

Every transfer presented on the check port carries an address and a non-secure flag. The block reports one cycle later whether the transfer may proceed. A non-secure transfer that lands on a block marked secure is refused. The first such refusal raises a pending flag and records the offending address and its attribute, and that record is kept until software acknowledges it.

A lock bit in the control register freezes the control register, the table pointer and the table contents until the next reset. The interrupt registers stay usable while the lock is set, so faults can still be handled.

Top module: `blkprot_ctrl`

## Requirements
- R1: Block n of the protected window, starting at byte offset n·2^(BLK_EXP+5) from RANGE_BASE, is governed by bit (n mod 32) of table word (n / 32). Offset 0x014 reads BLK_EXP. Offset 0x010 reads NUM_WORDS-1. Writes to both are ignored.
- R2: The check response comes one cycle after a valid check request, on chk_resp_valid. A non-secure request (chk_nonsec=1) to an in-window block whose bit is 0 is denied (chk_allow=0). Every secure request, every request to a block whose bit is 1, and every address outside the window is allowed.
- R3: Offset 0x018 holds the table word pointer, and offset 0x01C reads and writes the word it selects. After reset every table word is 0, so every block starts secure.
- R4: With control bit 8 set, the pointer advances by one after each window read and after each accepted window write, and it wraps from NUM_WORDS-1 to 0. With bit 8 clear, the pointer holds.
- R5: Writing control (offset 0x000) with bit 31 set engages the lock. While locked, writes to control, pointer and window are ignored, and the lock is released only by reset. Window reads still step the pointer while locked.
- R6: A denied check sets the pending flag, read at bit 0 of offset 0x020. It also records the address at offset 0x02C and the request attribute at offset 0x030, where bit 0 = 1 means non-secure.
- R7: While the pending flag is set, later denials do not overwrite the recorded address or attribute. After the flag is cleared, the next denial is recorded.
- R8: Writing 1 to bit 0 of offset 0x024 clears the pending flag, and writing 1 to bit 0 of offset 0x034 sets it. Bit 0 of offset 0x028 is the enable. irq_o equals pending AND enable. The interrupt registers are not affected by the lock.
- R9: Offset 0xFE0 reads HW_VER in bits 7:0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| chk_valid | input | 1 | Check request valid |
| chk_addr | input | 32 | Address to check |
| chk_nonsec | input | 1 | Request is non-secure |
| chk_resp_valid | output | 1 | Check response valid (one cycle later) |
| chk_allow | output | 1 | 1 = request allowed |
| irq_o | output | 1 | Interrupt, pending AND enable |

## Verification
The bench builds the block with NUM_WORDS=4, BLK_EXP=0 and RANGE_BASE=0x1000. This gives 128 blocks of 32 bytes, covering 0x1000 to 0x1FFF. At that size every block can be probed with both attributes against a table pattern computed in the bench, and the addresses just below and just above the window are also tested. The small pointer range makes the wrap of the auto-step reachable in four accesses. It also lets the locked state be checked against the full table contents.

// File: rtl/blkprot_pkg.sv
// Shared constants for the block protection controller: register offsets
// and control bit positions. Assumes a 32-bit register bus with 12-bit offsets.
package blkprot_pkg;
    localparam int WORD_BITS = 32;
    localparam int ADDR_W    = 32;
    localparam int OFS_W     = 12;

    localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h000;
    localparam logic [OFS_W-1:0] OFS_MAXIDX = 12'h010;
    localparam logic [OFS_W-1:0] OFS_BLKCFG = 12'h014;
    localparam logic [OFS_W-1:0] OFS_PTR    = 12'h018;
    localparam logic [OFS_W-1:0] OFS_WIN    = 12'h01C;
    localparam logic [OFS_W-1:0] OFS_ISTAT  = 12'h020;
    localparam logic [OFS_W-1:0] OFS_ICLR   = 12'h024;
    localparam logic [OFS_W-1:0] OFS_IEN    = 12'h028;
    localparam logic [OFS_W-1:0] OFS_FADDR  = 12'h02C;
    localparam logic [OFS_W-1:0] OFS_FATTR  = 12'h030;
    localparam logic [OFS_W-1:0] OFS_ISET   = 12'h034;
    localparam logic [OFS_W-1:0] OFS_ID0    = 12'hFE0;

    localparam int CTRL_STEP_BIT = 8;
    localparam int CTRL_LOCK_BIT = 31;
endpackage

// File: rtl/blkprot_table.sv
// Security bit table: NUM_WORDS words of 32 bits, one bit per block.
// Assumes NUM_WORDS is a power of two and at least 2. Bit value 1 = non-secure.
module blkprot_table #(
    parameter int NUM_WORDS = 8,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int NBLK     = NUM_WORDS * 32,
    localparam int BLK_W    = $clog2(NBLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   ptr,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic [BLK_W-1:0]   look_idx,
    output logic               look_bit,
    output logic [NBLK-1:0]    flat
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [31:0] q;
        // Holds one table word; cleared to all-secure on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && ptr == IDX_W'(w))
                q <= wr_data;
        end
        assign flat[w*32 +: 32] = q;
    end

    // Window read and per-block lookup taken from the flat view.
    assign rd_data  = flat[{ptr, 5'b0} +: 32];
    assign look_bit = flat[look_idx];
endmodule

// File: rtl/blkprot_cfg.sv
// Control and pointer state: step-enable bit, lock bit, and table pointer.
// Assumes at most one register access per cycle. The lock only clears on reset.
module blkprot_cfg #(
    parameter int NUM_WORDS = 8,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ptr_we,
    input  logic             win_step,
    input  logic [31:0]      wdata,
    output logic             step_en,
    output logic             lock,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] PTR_MAX = IDX_W'(NUM_WORDS - 1);

    // Control bits; writes are dropped once locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_en <= 1'b0;
            lock    <= 1'b0;
        end else if (ctrl_we && !lock) begin
            step_en <= wdata[blkprot_pkg::CTRL_STEP_BIT];
            lock    <= wdata[blkprot_pkg::CTRL_LOCK_BIT];
        end
    end

    // Table pointer: direct write when unlocked, otherwise auto-step on window use.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ptr_we && !lock)
            ptr <= wdata[IDX_W-1:0];
        else if (win_step && step_en)
            ptr <= (ptr == PTR_MAX) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/blkprot_check.sv
// Access check: maps an address to its block, looks up the table bit, and
// registers the allow/deny response. Addresses outside the window pass.
module blkprot_check #(
    parameter int NUM_WORDS            = 8,
    parameter int BLK_EXP              = 2,
    parameter logic [31:0] RANGE_BASE  = 32'h0,
    localparam int NBLK                = NUM_WORDS * 32,
    localparam int BLK_W               = $clog2(NBLK),
    localparam int SHIFT               = BLK_EXP + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic [31:0]      chk_addr,
    input  logic             chk_nonsec,
    input  logic             look_bit,
    output logic [BLK_W-1:0] look_idx,
    output logic             deny,
    output logic             resp_valid,
    output logic             allow
);
    logic [31:0] offset;
    logic [31:0] blk_full;
    logic        in_window;

    // Block number of the request relative to the window base.
    always_comb begin
        offset    = chk_addr - RANGE_BASE;
        blk_full  = offset >> SHIFT;
        in_window = (chk_addr >= RANGE_BASE) && (blk_full < 32'(NBLK));
        look_idx  = blk_full[BLK_W-1:0];
        deny      = chk_valid && chk_nonsec && in_window && !look_bit;
    end

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            allow      <= 1'b0;
        end else begin
            resp_valid <= chk_valid;
            allow      <= chk_valid && !deny;
        end
    end
endmodule

// File: rtl/blkprot_irq.sv
// Fault pending flag, enable, and first-fault record. A record is taken
// only when no fault is pending or the flag is being cleared in the same cycle.
module blkprot_irq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fault,
    input  logic [31:0] fault_addr,
    input  logic        fault_nonsec,
    input  logic        clr_hit,
    input  logic        set_hit,
    input  logic        en_we,
    input  logic        en_val,
    output logic        pend,
    output logic        ien,
    output logic [31:0] rec_addr,
    output logic        rec_nonsec,
    output logic        irq
);
    // Pending flag: fault or debug set win over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else
            pend <= fault || set_hit || (pend && !clr_hit);
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien <= 1'b0;
        else if (en_we)
            ien <= en_val;
    end

    // First-fault record of address and attribute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_addr   <= '0;
            rec_nonsec <= 1'b0;
        end else if (fault && (!pend || clr_hit)) begin
            rec_addr   <= fault_addr;
            rec_nonsec <= fault_nonsec;
        end
    end

    assign irq = pend && ien;
endmodule

// File: rtl/blkprot_ctrl.sv
// Top of the block protection controller: register decode and read mux,
// wiring of table, control, check and interrupt parts.
// Assumes a single-cycle register bus with combinational read data.
module blkprot_ctrl
    import blkprot_pkg::*;
#(
    parameter int NUM_WORDS           = 8,
    parameter int BLK_EXP             = 2,
    parameter logic [31:0] RANGE_BASE = 32'h0,
    parameter logic [7:0]  HW_VER     = 8'h3A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        chk_valid,
    input  logic [31:0] chk_addr,
    input  logic        chk_nonsec,
    output logic        chk_resp_valid,
    output logic        chk_allow,
    output logic        irq_o
);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int NBLK  = NUM_WORDS * 32;
    localparam int BLK_W = $clog2(NBLK);

    logic             wr_acc, rd_acc;
    logic             win_wr, win_rd, tbl_we, win_step;
    logic             clr_hit, set_hit, en_we;
    logic             step_en, lock_q;
    logic [IDX_W-1:0] ptr_q;
    logic [31:0]      tbl_rd;
    logic [BLK_W-1:0] look_idx;
    logic             look_bit, deny;
    logic [NBLK-1:0]  tbl_flat;
    logic             pend_q, ien_q, rec_nonsec;
    logic [31:0]      fault_addr_q;

    // Register access decode.
    always_comb begin
        wr_acc   = reg_en && reg_we;
        rd_acc   = reg_en && !reg_we;
        win_wr   = wr_acc && reg_addr == OFS_WIN;
        win_rd   = rd_acc && reg_addr == OFS_WIN;
        tbl_we   = win_wr && !lock_q;
        win_step = win_rd || tbl_we;
        clr_hit  = wr_acc && reg_addr == OFS_ICLR && reg_wdata[0];
        set_hit  = wr_acc && reg_addr == OFS_ISET && reg_wdata[0];
        en_we    = wr_acc && reg_addr == OFS_IEN;
    end

    blkprot_cfg #(.NUM_WORDS(NUM_WORDS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(wr_acc && reg_addr == OFS_CTRL),
        .ptr_we(wr_acc && reg_addr == OFS_PTR),
        .win_step(win_step), .wdata(reg_wdata),
        .step_en(step_en), .lock(lock_q), .ptr(ptr_q)
    );

    blkprot_table #(.NUM_WORDS(NUM_WORDS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .ptr(ptr_q), .wr_data(reg_wdata), .rd_data(tbl_rd),
        .look_idx(look_idx), .look_bit(look_bit), .flat(tbl_flat)
    );

    blkprot_check #(
        .NUM_WORDS(NUM_WORDS), .BLK_EXP(BLK_EXP), .RANGE_BASE(RANGE_BASE)
    ) u_check (
        .clk(clk), .rst_n(rst_n),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_nonsec(chk_nonsec),
        .look_bit(look_bit), .look_idx(look_idx), .deny(deny),
        .resp_valid(chk_resp_valid), .allow(chk_allow)
    );

    blkprot_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .fault(deny), .fault_addr(chk_addr), .fault_nonsec(chk_nonsec),
        .clr_hit(clr_hit), .set_hit(set_hit), .en_we(en_we), .en_val(reg_wdata[0]),
        .pend(pend_q), .ien(ien_q), .rec_addr(fault_addr_q), .rec_nonsec(rec_nonsec),
        .irq(irq_o)
    );

    // Read data mux; unmapped and write-only offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (rd_acc) begin
            case (reg_addr)
                OFS_CTRL:   reg_rdata = {lock_q, 22'b0, step_en, 8'b0};
                OFS_MAXIDX: reg_rdata = 32'(NUM_WORDS - 1);
                OFS_BLKCFG: reg_rdata = 32'(BLK_EXP);
                OFS_PTR:    reg_rdata = 32'(ptr_q);
                OFS_WIN:    reg_rdata = tbl_rd;
                OFS_ISTAT:  reg_rdata = {31'b0, pend_q};
                OFS_IEN:    reg_rdata = {31'b0, ien_q};
                OFS_FADDR:  reg_rdata = fault_addr_q;
                OFS_FATTR:  reg_rdata = {31'b0, rec_nonsec};
                OFS_ID0:    reg_rdata = {24'b0, HW_VER};
                default:    reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/blkprot_ctrl_chk.sv
// Property checker for blkprot_ctrl, attached through bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module blkprot_ctrl_chk #(
    parameter int NBLK = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_en,
    input logic            reg_we,
    input logic [11:0]     reg_addr,
    input logic [31:0]     reg_wdata,
    input logic            chk_valid,
    input logic            chk_nonsec,
    input logic            chk_resp_valid,
    input logic            chk_allow,
    input logic            irq_o,
    input logic            pend,
    input logic            ien,
    input logic            lock,
    input logic [NBLK-1:0] tbl,
    input logic [31:0]     finfo1
);
    logic clr_wr;
    assign clr_wr = reg_en && reg_we && reg_addr == blkprot_pkg::OFS_ICLR && reg_wdata[0];

    // R2
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_resp_valid);
    // R2
    sec_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_nonsec) |=> chk_allow);
    // R6
    deny_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_resp_valid && !chk_allow) |-> pend);
    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
    // R5
    lock_tbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(tbl));
    // R7
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_wr) |=> $stable(finfo1));
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq_o);
endmodule

bind blkprot_ctrl blkprot_ctrl_chk #(.NBLK(NUM_WORDS * 32)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .chk_valid(chk_valid),
    .chk_nonsec(chk_nonsec), .chk_resp_valid(chk_resp_valid), .chk_allow(chk_allow),
    .irq_o(irq_o), .pend(pend_q), .ien(ien_q), .lock(lock_q), .tbl(tbl_flat),
    .finfo1(fault_addr_q)
);

// File: tb/tb_blkprot_ctrl.sv
// Self-checking bench: 4 table words, 32-byte blocks, window at 0x1000.
module tb_blkprot_ctrl;
    localparam int NW = 4;
    localparam logic [31:0] BASE = 32'h1000;

    logic        clk = 0;
    logic        rst_n;
    logic        reg_en, reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        chk_valid, chk_nonsec, chk_resp_valid, chk_allow, irq_o;
    logic [31:0] chk_addr;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mdl [NW];

    always #5 clk = ~clk;

    blkprot_ctrl #(.NUM_WORDS(NW), .BLK_EXP(0), .RANGE_BASE(BASE), .HW_VER(8'h3A)) dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chk_valid(chk_valid),
        .chk_addr(chk_addr), .chk_nonsec(chk_nonsec), .chk_resp_valid(chk_resp_valid),
        .chk_allow(chk_allow), .irq_o(irq_o)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_en = 0;
    endtask

    task automatic rdc(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        cmp(tag, d, exp);
    endtask

    task automatic probe(input logic [31:0] a, input logic ns, output logic rv, output logic al);
        @(negedge clk);
        chk_valid = 1; chk_addr = a; chk_nonsec = ns;
        @(negedge clk);
        chk_valid = 0;
        #1 rv = chk_resp_valid; al = chk_allow;
    endtask

    function automatic logic [31:0] blk_addr(input int n);
        return BASE + 32'(n * 32) + 32'(n % 32);
    endfunction

    function automatic logic [31:0] pat(input int w);
        return 32'hA5C3_96E1 ^ (32'(w) * 32'h1111_1111);
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic rv, al;
        int first_den, second_den;
        rst_n = 0; reg_en = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        chk_valid = 0; chk_addr = 0; chk_nonsec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // Reset state (R1, R3, R8, R9)
        rdc("R5 ctrl reset", 12'h000, 32'h0);
        rdc("R1 max word index", 12'h010, 32'd3);
        rdc("R1 block cfg", 12'h014, 32'd0);
        wr(12'h014, 32'h7); wr(12'h010, 32'h9);
        rdc("R1 cfg read-only", 12'h014, 32'd0);
        rdc("R1 maxidx read-only", 12'h010, 32'd3);
        rdc("R3 pointer reset", 12'h018, 32'd0);
        rdc("R6 status reset", 12'h020, 32'd0);
        cmp("R8 irq reset", {31'b0, irq_o}, 32'd0);
        rdc("R9 id0", 12'hFE0, 32'h3A);
        rdc("R9 unmapped", 12'h040, 32'h0);
        for (int w = 0; w < NW; w++) begin
            wr(12'h018, 32'(w));
            rdc("R3 table reset zero", 12'h01C, 32'h0);
        end

        // Fill and read back without auto-step (R3)
        for (int w = 0; w < NW; w++) begin
            mdl[w] = pat(w);
            wr(12'h018, 32'(w));
            wr(12'h01C, mdl[w]);
        end
        for (int w = 0; w < NW; w++) begin
            wr(12'h018, 32'(w));
            rdc("R3 table readback", 12'h01C, mdl[w]);
        end
        // Pointer holds when step disabled (R4)
        wr(12'h018, 32'd2);
        rdc("R4 no-step read", 12'h01C, mdl[2]);
        rdc("R4 no-step read", 12'h01C, mdl[2]);
        rdc("R4 pointer held", 12'h018, 32'd2);

        // Exhaustive block sweep (R1, R2, R6)
        first_den = -1; second_den = -1;
        for (int n = 0; n < NW * 32; n++) begin
            logic exp_al;
            exp_al = mdl[n / 32][n % 32];
            if (!exp_al && first_den < 0) first_den = n;
            else if (!exp_al && second_den < 0) second_den = n;
            probe(blk_addr(n), 1'b1, rv, al);
            cmp("R2 resp valid", {31'b0, rv}, 32'd1);
            cmp("R1 R2 nonsec lookup", {31'b0, al}, {31'b0, exp_al});
            probe(blk_addr(n), 1'b0, rv, al);
            cmp("R2 secure allowed", {31'b0, al}, 32'd1);
        end
        probe(BASE - 32'd4, 1'b1, rv, al);
        cmp("R2 below window", {31'b0, al}, 32'd1);
        probe(BASE + 32'(NW * 32 * 32), 1'b1, rv, al);
        cmp("R2 above window", {31'b0, al}, 32'd1);
        @(negedge clk);
        cmp("R2 idle no resp", {31'b0, chk_resp_valid}, 32'd0);

        rdc("R6 pending", 12'h020, 32'd1);
        rdc("R6 fault address", 12'h02C, blk_addr(first_den));
        rdc("R6 fault attribute", 12'h030, 32'd1);

        // Record held until clear (R7)
        wr(12'h024, 32'd1);
        rdc("R8 cleared", 12'h020, 32'd0);
        probe(blk_addr(first_den), 1'b1, rv, al);
        probe(blk_addr(second_den), 1'b1, rv, al);
        rdc("R7 first kept", 12'h02C, blk_addr(first_den));
        wr(12'h024, 32'd1);
        probe(blk_addr(second_den), 1'b1, rv, al);
        rdc("R7 new record", 12'h02C, blk_addr(second_den));

        // Interrupt enable, clear, set (R8)
        cmp("R8 irq masked", {31'b0, irq_o}, 32'd0);
        wr(12'h028, 32'd1);
        rdc("R8 enable", 12'h028, 32'd1);
        cmp("R8 irq on", {31'b0, irq_o}, 32'd1);
        wr(12'h024, 32'd1);
        cmp("R8 irq cleared", {31'b0, irq_o}, 32'd0);
        wr(12'h034, 32'd1);
        cmp("R8 irq set", {31'b0, irq_o}, 32'd1);
        rdc("R8 set status", 12'h020, 32'd1);
        wr(12'h024, 32'd1);

        // Auto-step writes and reads with wrap (R4)
        wr(12'h000, 32'h0000_0100);
        rdc("R4 ctrl step", 12'h000, 32'h0000_0100);
        wr(12'h018, 32'd0);
        for (int w = 0; w < NW; w++) begin
            mdl[w] = 32'h0F0F_33CC + 32'(w) * 32'h0101_0101;
            wr(12'h01C, mdl[w]);
        end
        rdc("R4 pointer wrapped", 12'h018, 32'd0);
        for (int w = 0; w < NW; w++) rdc("R4 stepped read", 12'h01C, mdl[w]);
        rdc("R4 pointer wrap read", 12'h018, 32'd0);

        // Lockdown (R5)
        wr(12'h000, 32'h8000_0100);
        rdc("R5 lock set", 12'h000, 32'h8000_0100);
        wr(12'h000, 32'h0);
        rdc("R5 ctrl frozen", 12'h000, 32'h8000_0100);
        wr(12'h018, 32'd2);
        rdc("R5 pointer frozen", 12'h018, 32'd0);
        wr(12'h01C, 32'hFFFF_FFFF);
        rdc("R5 table frozen", 12'h01C, mdl[0]);
        rdc("R5 read still steps", 12'h018, 32'd1);
        for (int w = 0; w < NW; w++) begin
            rdc("R5 table intact", 12'h01C, mdl[(w + 1) % NW]);
        end
        probe(blk_addr(0), 1'b1, rv, al);
        cmp("R5 locked lookup", {31'b0, al}, {31'b0, mdl[0][0]});
        wr(12'h024, 32'd1);
        wr(12'h034, 32'd1);
        cmp("R8 irq while locked", {31'b0, irq_o}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule